// File: doc/BRIEF.md
# Prescaled Compare-Match Up-Timer

The block is a 24-bit up-counter. An 8-bit clock divider drives it, or in event mode the edges of an external pin drive it. It compares each new count with a programmable 24-bit limit. When the two are equal it raises a sticky match flag. That flag feeds an interrupt line and a wake-up request, each behind its own enable. Four operating modes decide what happens after a match: stop (one-shot), reload (periodic), reload and invert an output (toggle), or keep counting and wrap (continuous). A debug-halt input can freeze counting unless a free-run bit overrides it.

Software reaches the block through a flat register port. A single-cycle write strobe carries a 2-bit address and a 32-bit word, and a combinational read returns the register the address selects. Address 0 is the control word, 1 the compare limit, 2 the status flags (write 1 to clear) and 3 the count readback. A small state machine in the counter core tracks whether the timer is stopped (IDLE), counting (COUNT) or held by debug (FROZEN). Its transitions are: start (IDLE to COUNT when the run bit is set with no halt), start-frozen (IDLE to FROZEN when run is set during a halt), freeze (COUNT to FROZEN on an effective halt), thaw (FROZEN to COUNT when the halt drops), and stop (COUNT or FROZEN to IDLE when run clears, whether by a write, a soft reset or a one-shot match).

Top module: `cm_uptimer`

## Requirements
- R1: With event mode off, the counter advances once every (P+1) clock cycles, where P is control bits [7:0]. In periodic mode (control bits [15:14] = 01) with compare value C, consecutive matches are exactly (P+1)*C cycles apart.
- R2: When the count takes the compare value (address 1, bits [23:0]), status bit 0 is set. Writing 1 to status bit 0 clears it and writing 0 leaves it set; a new match in the same cycle as a clear wins.
- R3: The `irq` output is high exactly when status bit 0 is set and the interrupt enable (control bit 16) is 1.
- R4: A control write with bit 13 set clears the divider and the counter and leaves the run bit (control bit 17) at 0, whatever value is written to bit 17. Bit 13 reads back as 0.
- R5: A compare write in any mode other than continuous (11) restarts the count from 0. In continuous mode the count carries on undisturbed.
- R6: In one-shot mode (00) a match returns the count to 0 and clears the run bit, so counting stops.
- R7: In toggle mode (10) a match returns the count to 0 and inverts the `tog` output. Matches recur every (P+1)*C cycles.
- R8: In continuous mode (11) a match leaves the count running past the compare value, and the count wraps at 2^24.
- R9: While the live-load bit (control bit 8) is 1, address 3 follows the counter. While it is 0, address 3 holds its last value.
- R10: With event mode on (control bit 10), the counter advances once per edge of `evt_pin` and ignores the divider. The edge is rising when control bit 11 is 1 and falling when it is 0.
- R11: With the filter bit (control bit 12) set, a pin level that lasts a single clock cycle is not counted. With the bit clear, such a pulse is counted.
- R12: While the wake enable (control bit 9) is 1 and status bit 0 is set, `wake` is high and status bit 1 becomes set. Status bit 1 stays set until 1 is written to it.
- R13: Control bit 19 (read-only) is 1 only while the core is in state COUNT.
- R14: While `dbg_halt` is 1 and the free-run bit (control bit 18) is 0, the count does not change. With bit 18 set, the halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pin | input | 1 | External event pin, asynchronous |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up trigger |
| tog | output | 1 | Output inverted on each toggle-mode match |

## Verification
The embedded assertions check four things every cycle. The count only ever steps by one or falls to zero. A soft reset and a restarting compare write leave a zero count. A halted, non-overridden core holds its count, and a one-shot match stops the run bit. They also check that every match sets the flag and every toggle-mode match inverts `tog`. Only the bench scenarios can show the exact match spacing for each divider and limit, which edge polarity counts, that the filter rejects one-cycle pulses, and how the wake flag sticks after the match flag is cleared.

// File: rtl/cm_uptimer_pkg.sv
package cm_uptimer_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_TOGGLE   = 2'b10,
        MODE_CONT     = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COUNT  = 2'b01,
        ST_FROZEN = 2'b10
    } tmr_state_e;

    localparam int REG_DW = 32;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_CMP  = 2'd1;
    localparam logic [REG_AW-1:0] A_STS  = 2'd2;
    localparam logic [REG_AW-1:0] A_CNT  = 2'd3;

    // control word bit positions
    localparam int B_LIVE  = 8;
    localparam int B_WAKE  = 9;
    localparam int B_EVT   = 10;
    localparam int B_RISE  = 11;
    localparam int B_FILT  = 12;
    localparam int B_SRST  = 13;
    localparam int B_MODE  = 14;
    localparam int B_IEN   = 16;
    localparam int B_RUN   = 17;
    localparam int B_FREE  = 18;
    localparam int B_ACT   = 19;

endpackage

// File: rtl/cm_divider.sv
module cm_divider #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] pcnt_q;

    assign tick_o = en_i && (pcnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr_i) begin
            pcnt_q <= '0;
        end else if (en_i) begin
            pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cm_pin_edge.sv
module cm_pin_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic filt_en_i,
    input  logic rise_sel_i,
    output logic edge_o
);

    logic [SYNC_N-1:0] sync_q;
    logic              samp_q;
    logic              filt_q;
    logic              prev_q;
    logic              s_now;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_N-2:0], pin_i};
            end
        end
    endgenerate

    assign s_now = sync_q[SYNC_N-1];

    // two-sample agreement filter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            filt_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= s_now;
            if (!filt_en_i || (s_now == samp_q)) filt_q <= s_now;
            prev_q <= filt_q;
        end
    end

    assign edge_o = rise_sel_i ? (filt_q & ~prev_q) : (~filt_q & prev_q);

    p_filter_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en_i && (s_now != samp_q)) |=> $stable(filt_q));

endmodule

// File: rtl/cm_count_core.sv
module cm_count_core
    import cm_uptimer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             halt_i,
    input  tmr_mode_e        mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic             go_o,
    output logic             active_o,
    output logic             match_o,
    output logic             tog_o,
    output logic [CNT_W-1:0] cnt_o
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;
    logic             hit;
    logic             tog_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: start, start-frozen, freeze, thaw, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) state_d = halt_i ? ST_FROZEN : ST_COUNT;
            end
            ST_COUNT: begin
                if (!run_i)      state_d = ST_IDLE;
                else if (halt_i) state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (!run_i)       state_d = ST_IDLE;
                else if (!halt_i) state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        go_o     = (state_q == ST_COUNT) && run_i && !halt_i;
        active_o = (state_q == ST_COUNT);
    end

    assign step    = go_o && tick_i;
    assign cnt_nxt = cnt_q + 1'b1;
    assign hit     = step && (cnt_nxt == cmp_i);
    assign match_o = hit && !clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (hit && (mode_i != MODE_CONT)) ? '0 : cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                tog_q <= 1'b0;
        else if (match_o && mode_i == MODE_TOGGLE) tog_q <= ~tog_q;
    end

    assign cnt_o = cnt_q;
    assign tog_o = tog_q;

    p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

    p_halt_freeze_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !clr_i) |=> $stable(cnt_q));

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && mode_i == MODE_TOGGLE) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/cm_uptimer.sv
module cm_uptimer
    import cm_uptimer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              evt_pin,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              wake,
    output logic              tog
);

    localparam int CNT_PAD = REG_DW - CNT_W;
    localparam int PRE_PAD = B_LIVE - PRE_W;

    logic [PRE_W-1:0] pre_q;
    logic             live_q, wake_en_q, evt_q, rise_q, filt_q, ien_q, run_q, free_q;
    tmr_mode_e        mode_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] data_q;
    logic             flag_q, wflag_q;

    logic             wr_ctl, wr_cmp, wr_sts;
    logic             soft_rst, restart, clr;
    logic             halt_eff, go, active, match;
    logic             div_tick, pin_edge, tick;
    logic [CNT_W-1:0] cnt;
    logic             wake_cond;

    assign wr_ctl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_cmp   = reg_wr && (reg_addr == A_CMP);
    assign wr_sts   = reg_wr && (reg_addr == A_STS);
    assign soft_rst = wr_ctl && reg_wdata[B_SRST];
    assign restart  = wr_cmp && (mode_q != MODE_CONT);
    assign clr      = soft_rst || restart;
    assign halt_eff = dbg_halt && !free_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q     <= '0;
            live_q    <= 1'b0;
            wake_en_q <= 1'b0;
            evt_q     <= 1'b0;
            rise_q    <= 1'b0;
            filt_q    <= 1'b0;
            mode_q    <= MODE_ONESHOT;
            ien_q     <= 1'b0;
            free_q    <= 1'b0;
        end else if (wr_ctl) begin
            pre_q     <= reg_wdata[PRE_W-1:0];
            live_q    <= reg_wdata[B_LIVE];
            wake_en_q <= reg_wdata[B_WAKE];
            evt_q     <= reg_wdata[B_EVT];
            rise_q    <= reg_wdata[B_RISE];
            filt_q    <= reg_wdata[B_FILT];
            mode_q    <= tmr_mode_e'(reg_wdata[B_MODE +: 2]);
            ien_q     <= reg_wdata[B_IEN];
            free_q    <= reg_wdata[B_FREE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               run_q <= 1'b0;
        else if (wr_ctl)                          run_q <= reg_wdata[B_RUN] & ~reg_wdata[B_SRST];
        else if (match && mode_q == MODE_ONESHOT) run_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= reg_wdata[CNT_W-1:0];
    end

    cm_divider #(.PRE_W(PRE_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .en_i   (go && !evt_q),
        .div_i  (pre_q),
        .tick_o (div_tick)
    );

    cm_pin_edge #(.SYNC_N(SYNC_N)) i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (evt_pin),
        .filt_en_i  (filt_q),
        .rise_sel_i (rise_q),
        .edge_o     (pin_edge)
    );

    assign tick = evt_q ? pin_edge : div_tick;

    cm_count_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .halt_i   (halt_eff),
        .mode_i   (mode_q),
        .cmp_i    (cmp_q),
        .clr_i    (clr),
        .tick_i   (tick),
        .go_o     (go),
        .active_o (active),
        .match_o  (match),
        .tog_o    (tog),
        .cnt_o    (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (live_q) data_q <= cnt;
    end

    assign wake_cond = wake_en_q && flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            wflag_q <= 1'b0;
        end else begin
            if (match)                        flag_q <= 1'b1;
            else if (wr_sts && reg_wdata[0])  flag_q <= 1'b0;
            if (wake_cond)                    wflag_q <= 1'b1;
            else if (wr_sts && reg_wdata[1])  wflag_q <= 1'b0;
        end
    end

    assign irq  = flag_q && ien_q;
    assign wake = wake_cond;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: reg_rdata = {12'b0, active, free_q, run_q, ien_q, mode_q, 1'b0,
                                 filt_q, rise_q, evt_q, wake_en_q, live_q,
                                 {PRE_PAD{1'b0}}, pre_q};
            A_CMP:  reg_rdata = {{CNT_PAD{1'b0}}, cmp_q};
            A_STS:  reg_rdata = {30'b0, wflag_q, flag_q};
            A_CNT:  reg_rdata = {{CNT_PAD{1'b0}}, data_q};
            default: reg_rdata = '0;
        endcase
    end

    p_match_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_q == MODE_ONESHOT && !wr_ctl) |=> !run_q);

    p_soft_rst_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!run_q && cnt == '0));

    p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    p_wake_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> wflag_q);

endmodule

// File: tb/test_cm_uptimer.sv
module test_cm_uptimer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_pin = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq, wake, tog;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cm_uptimer i_cm_uptimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pin   (evt_pin),
        .dbg_halt  (dbg_halt),
        .irq       (irq),
        .wake      (wake),
        .tog       (tog)
    );

    // vectors: mode, prescale, compare, expected match spacing in cycles
    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  pre;
        logic [23:0] cmp;
        logic [31:0] gap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, 8'd0, 24'd5,  32'd5},
        '{2'b01, 8'd2, 24'd4,  32'd12},
        '{2'b01, 8'd7, 24'd3,  32'd24},
        '{2'b01, 8'd0, 24'd3,  32'd3},
        '{2'b10, 8'd1, 24'd6,  32'd12},
        '{2'b10, 8'd3, 24'd2,  32'd8}
    };

    function automatic logic [31:0] ctl(input int pre, input bit live, input bit wk,
                                        input bit evt, input bit rise, input bit filt,
                                        input bit srst, input int mode, input bit ien,
                                        input bit run, input bit free);
        logic [31:0] w;
        w = '0;
        w[7:0]   = pre[7:0];
        w[8]     = live;
        w[9]     = wk;
        w[10]    = evt;
        w[11]    = rise;
        w[12]    = filt;
        w[13]    = srst;
        w[15:14] = mode[1:0];
        w[16]    = ien;
        w[17]    = run;
        w[18]    = free;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int t, output bit seen);
        seen = 1'b0; t = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (irq) begin t = cyc; seen = 1'b1; return; end
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk); evt_pin = 1'b1;
        repeat (hi) @(negedge clk);
        evt_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic fresh(input logic [23:0] c);
        wr(0, ctl(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
        wr(1, {8'd0, c});
        wr(2, 32'h3);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int t0, t1;
        bit s0, s1;
        logic tg0, tg1;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        rd(0, v); chk("R13 reset ctrl", v, 32'h0);
        rd(1, v); chk("R5 reset cmp", v, 32'h0);
        rd(2, v); chk("R2 reset status", v, 32'h0);
        rd(3, v); chk("R9 reset data", v, 32'h0);
        chk("R3 reset irq", irq, 1'b0);
        chk("R12 reset wake", wake, 1'b0);
        chk("R7 reset tog", tog, 1'b0);

        // R1 / R7 table: match spacing
        foreach (VECS[k]) begin
            fresh(VECS[k].cmp);
            wr(0, ctl(VECS[k].pre, 0, 0, 0, 0, 0, 0, VECS[k].mode, 1, 1, 0));
            wait_irq(t0, s0); tg0 = tog;
            wr(2, 32'h1);
            wait_irq(t1, s1); tg1 = tog;
            chk("R1 match seen", {30'b0, s0, s1}, 32'h3);
            chk("R1 R7 match spacing", t1 - t0, VECS[k].gap);
            if (VECS[k].mode == 2'b10) chk("R7 tog inverted", tg1 ^ tg0, 1'b1);
        end

        // R2 / R3: flag sticks without enable, write-one-to-clear
        fresh(24'd4);
        wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        idle(12);
        chk("R3 irq held low with enable off", irq, 1'b0);
        rd(2, v); chk("R2 flag set on match", v, 32'h1);
        wr(2, 32'h0);
        rd(2, v); chk("R2 writing 0 keeps flag", v, 32'h1);
        wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        chk("R3 irq with enable on", irq, 1'b1);
        wr(2, 32'h1);
        rd(2, v); chk("R2 writing 1 clears flag", v, 32'h0);
        chk("R3 irq drops with flag", irq, 1'b0);

        // R6 one-shot
        fresh(24'd10);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        idle(30);
        rd(0, v); chk("R6 run cleared after one-shot", v[17], 1'b0);
        chk("R13 inactive after one-shot", v[19], 1'b0);
        rd(3, v); chk("R6 count back at 0", v, 32'h0);
        rd(2, v); chk("R6 flag set", v, 32'h1);

        // R8 continuous passes the match
        fresh(24'd10);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 3, 1, 1, 0));
        idle(20);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 3, 1, 0, 0));
        idle(3);
        rd(3, v);
        chk("R8 count beyond compare", {31'b0, v > 32'd12}, 32'h1);
        rd(2, v2); chk("R8 flag set", v2, 32'h1);

        // R5 continuous: compare write does not restart
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 3, 0, 1, 0));
        idle(5);
        rd(3, v);
        wr(1, 32'd500);
        idle(3);
        rd(3, v2);
        chk("R5 continuous not restarted", {31'b0, v2 > v}, 32'h1);

        // R5 periodic: compare write restarts
        fresh(24'd1000);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0));
        idle(100);
        wr(1, 32'd900);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0));
        idle(3);
        rd(3, v);
        chk("R5 periodic restarted", {31'b0, v < 32'd5}, 32'h1);

        // R4 soft reset
        fresh(24'd1000);
        wr(0, ctl(5, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0));
        idle(200);
        wr(0, ctl(5, 1, 0, 0, 0, 0, 1, 1, 0, 1, 0));
        rd(0, v); chk("R4 run forced low", v[17], 1'b0);
        chk("R4 reset bit reads 0", v[13], 1'b0);
        idle(3);
        rd(3, v); chk("R4 count cleared", v, 32'h0);

        // R9 live load off holds, on tracks; R13 active
        fresh(24'd100000);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0));
        idle(10);
        rd(0, v); chk("R13 active while counting", v[19], 1'b1);
        wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0));
        rd(3, v); idle(20); rd(3, v2);
        chk("R9 data held with live off", v2, v);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0));
        idle(3);
        rd(3, v2);
        chk("R9 data tracks with live on", {31'b0, v2 > v + 32'd15}, 32'h1);

        // R14 debug halt
        dbg_halt = 1'b1;
        idle(3);
        rd(3, v); idle(20); rd(3, v2);
        chk("R14 count frozen by halt", v2, v);
        rd(0, v2); chk("R13 inactive while frozen", v2[19], 1'b0);
        wr(0, ctl(0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 1));
        idle(20);
        rd(3, v2);
        chk("R14 free-run overrides halt", {31'b0, v2 > v + 32'd10}, 32'h1);
        dbg_halt = 1'b0;

        // R10 event mode, rising edges
        fresh(24'd1000);
        wr(0, ctl(0, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0));
        idle(20);
        rd(3, v); chk("R10 no count without edges", v, 32'h0);
        for (int p = 0; p < 5; p++) pulse(3, 3);
        idle(8);
        rd(3, v); chk("R10 five rising edges", v, 32'd5);
        // falling edges
        wr(0, ctl(0, 1, 0, 1, 0, 0, 0, 1, 0, 1, 0));
        @(negedge clk); evt_pin = 1'b1;
        idle(10);
        rd(3, v); chk("R10 rising ignored in falling phase", v, 32'd5);
        evt_pin = 1'b0;
        idle(10);
        rd(3, v); chk("R10 falling edge counted", v, 32'd6);

        // R11 filter
        wr(0, ctl(0, 1, 0, 1, 1, 1, 0, 1, 0, 1, 0));
        pulse(1, 8);
        idle(4);
        rd(3, v); chk("R11 filtered short pulse", v, 32'd6);
        pulse(3, 8);
        idle(4);
        rd(3, v); chk("R11 long pulse passes filter", v, 32'd7);
        wr(0, ctl(0, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0));
        pulse(1, 8);
        idle(4);
        rd(3, v); chk("R11 short pulse counted unfiltered", v, 32'd8);

        // R12 wake
        fresh(24'd4);
        wr(0, ctl(0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0));
        idle(12);
        chk("R12 wake high", wake, 1'b1);
        rd(2, v); chk("R12 both flags set", v, 32'h3);
        wr(2, 32'h1);
        chk("R12 wake drops with match flag", wake, 1'b0);
        rd(2, v); chk("R12 wake flag sticky", v, 32'h2);
        wr(2, 32'h2);
        rd(2, v); chk("R12 wake flag cleared", v, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule